// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts the direction of conditional branches. It keeps a two-bit global history of the last two resolved branches, whichever static branches they were. Each static branch, selected by a small index taken from its address, owns four one-bit direction entries, one for each history pattern. A lookup returns the entry chosen by the branch index and the current history. A resolve writes the real outcome into that one entry and then shifts the outcome into the history.

A mode input turns off the history selection. In that mode every branch reads and writes only its pattern-0 slot, so the block behaves as a plain one-bit last-outcome predictor. This allows the two schemes to be compared on the same branch stream. At every resolve the block also compares the outcome with its own prediction for that branch and counts correct and incorrect guesses.

Top module: `gcp_predictor`

## Requirements
- R1: After a synchronous active-low reset, the history is 2'b00, every entry predicts not-taken (`lk_taken`=0 for every index), and both counters are 0.
- R2: With `hist_en`=1, `lk_taken` equals the entry of branch `lk_idx` at pattern code {older outcome, newest outcome} = `ghist`. The codes are 3 = both taken, 1 = newest taken and older not taken, 2 = newest not taken and older taken, 0 = both not taken.
- R3: A resolve overwrites only the entry at the selected pattern of branch `rs_idx` with `rs_taken`. The other three patterns of that branch and all other branches keep their values.
- R4: On a resolve, `ghist[0]` becomes `rs_taken` and `ghist[1]` takes the previous `ghist[0]`, one cycle after the request.
- R5: The history is shared. A resolve of any branch index shifts it and changes which pattern every branch uses next.
- R6: With `hist_en`=0, lookups and updates both use pattern 0 only, so a branch predicts its own last outcome in that mode. The history still shifts.
- R7: When a lookup and a resolve fall in the same cycle, `lk_taken` reflects the state before that resolve.
- R8: On each resolve, `hit_cnt` rises by one if `rs_taken` equals the prediction the block gives for `rs_idx` in that cycle, and `miss_cnt` rises by one otherwise. Both counters saturate at their maximum.
- R9: Without a resolve, history, entries and counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hist_en | input | 1 | 1: select entry by global history; 0: pattern 0 only |
| lk_idx | input | IDX_W | Branch index for lookup |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| rs_valid | input | 1 | Resolve request this cycle |
| rs_idx | input | IDX_W | Branch index being resolved |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| ghist | output | 2 | Global history, bit 0 newest |
| hit_cnt | output | CNT_W | Count of correct predictions |
| miss_cnt | output | CNT_W | Count of incorrect predictions |

## Verification
Lookup and resolve can occur in the same clock cycle, and the resolve may name the very entry being looked up. The bench drives a resolve and a lookup of the same branch together. It samples `lk_taken` before the edge and expects the old value. It then steers the history back to the same pattern and expects the new value. A checker ties the lookup value in that cycle to which counter advanced.

// File: rtl/gcp_pkg.sv
// Shared constants and types for the correlating predictor.
// Assumes a fixed two-outcome global history.
package gcp_pkg;
    localparam int HIST_W  = 2;
    localparam int N_PATT  = 1 << HIST_W;
    typedef logic [HIST_W-1:0] patt_t;   // {older outcome, newest outcome}
    typedef logic [N_PATT-1:0] slots_t;  // one direction bit per pattern
endpackage

// File: rtl/gcp_history.sv
// Global outcome shift register. Bit 0 is the newest outcome.
// Assumes shift_en pulses once per resolved branch.
module gcp_history
    import gcp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  shift_en,
    input  logic  bit_in,
    output patt_t hist
);
    // Shift the resolved outcome in as the newest bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[0], bit_in};
    end
endmodule

// File: rtl/gcp_table.sv
// Per-branch direction entries, four patterns per branch.
// It has two combinational read ports, one for lookup and one for the
// resolve-time comparison, and one write port. Reads return pre-write state.
module gcp_table
    import gcp_pkg::*;
#(
    parameter int IDX_W = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  patt_t            rd_patt,
    output logic             rd_bit,
    input  logic [IDX_W-1:0] cmp_idx,
    input  patt_t            cmp_patt,
    output logic             cmp_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  patt_t            wr_patt,
    input  logic             wr_bit
);
    localparam int N_BR = 1 << IDX_W;

    slots_t ent [N_BR];

    // One storage row per static branch; only the addressed bit is written.
    for (genvar b = 0; b < N_BR; b++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[b] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(b)))
                ent[b][wr_patt] <= wr_bit;
        end
    end

    // Lookup read port.
    always_comb rd_bit = ent[rd_idx][rd_patt];

    // Comparison read port used to score the resolve.
    always_comb cmp_bit = ent[cmp_idx][cmp_patt];
endmodule

// File: rtl/gcp_stats.sv
// Saturating counters for correct and incorrect predictions.
// Assumes en is high for exactly the cycles with a resolve.
module gcp_stats #(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             correct,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Advance the counter that matches the outcome of the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt  <= '0;
            miss_cnt <= '0;
        end else if (en) begin
            if (correct && hit_cnt != CNT_MAX)
                hit_cnt <= hit_cnt + 1'b1;
            else if (!correct && miss_cnt != CNT_MAX)
                miss_cnt <= miss_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gcp_predictor.sv
// Correlating branch direction predictor with a two-bit global history.
// It looks up combinationally and updates on the clock edge, so a lookup
// in the same cycle as a resolve sees the old state. With hist_en low,
// pattern 0 is used everywhere.
module gcp_predictor
    import gcp_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hist_en,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_taken,
    input  logic             rs_valid,
    input  logic [IDX_W-1:0] rs_idx,
    input  logic             rs_taken,
    output logic [1:0]       ghist,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    patt_t hist_q;
    patt_t sel_patt;
    logic  rs_pred;

    // Pattern used by both ports: the history, or 0 when it is disabled.
    always_comb sel_patt = hist_en ? hist_q : '0;

    gcp_history u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rs_valid),
        .bit_in   (rs_taken),
        .hist     (hist_q)
    );

    gcp_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_patt  (sel_patt),
        .rd_bit   (lk_taken),
        .cmp_idx  (rs_idx),
        .cmp_patt (sel_patt),
        .cmp_bit  (rs_pred),
        .wr_en    (rs_valid),
        .wr_idx   (rs_idx),
        .wr_patt  (sel_patt),
        .wr_bit   (rs_taken)
    );

    gcp_stats #(.CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rs_valid),
        .correct  (rs_pred == rs_taken),
        .hit_cnt  (hit_cnt),
        .miss_cnt (miss_cnt)
    );

    // Expose the history register.
    always_comb ghist = hist_q;
endmodule

// File: rtl/gcp_checker.sv
// Temporal checks on the predictor ports, attached by bind.
module gcp_checker #(
    parameter int IDX_W = 2,
    parameter int CNT_W = 16
)(
    input logic             clk,
    input logic             rst_n,
    input logic             hist_en,
    input logic [IDX_W-1:0] lk_idx,
    input logic             lk_taken,
    input logic             rs_valid,
    input logic [IDX_W-1:0] rs_idx,
    input logic             rs_taken,
    input logic [1:0]       ghist,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |=> (ghist[0] == $past(rs_taken)) && (ghist[1] == $past(ghist[0]))); // R4

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> $stable(ghist)); // R9

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> $stable(hit_cnt) && $stable(miss_cnt)); // R9

    AST_CNT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && hit_cnt != CMAX && miss_cnt != CMAX) |=>
        $countones({hit_cnt != $past(hit_cnt), miss_cnt != $past(miss_cnt)}) == 1); // R8

    AST_SAME_CYCLE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && lk_idx == rs_idx && hit_cnt != CMAX && miss_cnt != CMAX) |=>
        ((hit_cnt != $past(hit_cnt)) == ($past(lk_taken) == $past(rs_taken)))); // R7

    AST_FLAT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hist_en && rs_valid) |=>
        ((!hist_en && lk_idx == $past(rs_idx)) ? (lk_taken == $past(rs_taken)) : 1'b1)); // R6
endmodule

bind gcp_predictor gcp_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_gcp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .hist_en  (hist_en),
    .lk_idx   (lk_idx),
    .lk_taken (lk_taken),
    .rs_valid (rs_valid),
    .rs_idx   (rs_idx),
    .rs_taken (rs_taken),
    .ghist    (ghist),
    .hit_cnt  (hit_cnt),
    .miss_cnt (miss_cnt)
);

// File: tb/gcp_predictor_bench.sv
module gcp_predictor_bench;
    localparam int IDX_W = 2;
    localparam int CNT_W = 16;
    localparam int NV    = 12;
    // Vector fields: {idx[1:0], outcome, expected prediction, expected ghist after[1:0]}
    localparam logic [5:0] VEC [NV] = '{
        6'b00_1_0_01, 6'b01_1_0_11, 6'b00_0_0_10, 6'b00_1_0_01,
        6'b01_1_1_11, 6'b00_0_0_10, 6'b00_1_1_01, 6'b10_0_0_10,
        6'b11_1_0_01, 6'b00_0_0_10, 6'b11_1_1_01, 6'b01_0_1_10
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hist_en = 1'b1;
    logic [IDX_W-1:0] lk_idx = '0;
    logic             lk_taken;
    logic             rs_valid = 1'b0;
    logic [IDX_W-1:0] rs_idx = '0;
    logic             rs_taken = 1'b0;
    logic [1:0]       ghist;
    logic [CNT_W-1:0] hit_cnt, miss_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    gcp_predictor #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_gcp_predictor (
        .clk(clk), .rst_n(rst_n), .hist_en(hist_en), .lk_idx(lk_idx),
        .lk_taken(lk_taken), .rs_valid(rs_valid), .rs_idx(rs_idx),
        .rs_taken(rs_taken), .ghist(ghist), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rs_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic resolve(input logic [IDX_W-1:0] idx, input logic t);
        rs_idx = idx; rs_taken = t; rs_valid = 1'b1;
        @(posedge clk);
        #1 rs_valid = 1'b0;
    endtask

    task automatic look(input logic [IDX_W-1:0] idx, input int exp, input string req);
        lk_idx = idx;
        #1 chk(req, int'(lk_taken), exp);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 ghist", int'(ghist), 0);
        chk("R1 hit_cnt", int'(hit_cnt), 0);
        chk("R1 miss_cnt", int'(miss_cnt), 0);
        for (int b = 0; b < 4; b++) look(IDX_W'(b), 0, "R1 entry");

        // R2 R4 R5 R3: table walk over several branches sharing one history
        for (int i = 0; i < NV; i++) begin
            look(VEC[i][5:4], int'(VEC[i][2]), "R2 lookup");
            resolve(VEC[i][5:4], VEC[i][3]);
            chk("R4/R5 ghist", int'(ghist), int'(VEC[i][1:0]));
        end
        // R8: 7 correct, 5 wrong across the walk
        chk("R8 hit_cnt", int'(hit_cnt), 7);
        chk("R8 miss_cnt", int'(miss_cnt), 5);

        // R9: idle cycles change nothing
        lk_idx = 2'd3;
        repeat (4) @(posedge clk);
        #1;
        chk("R9 ghist", int'(ghist), 2);
        chk("R9 lookup", int'(lk_taken), 1);
        chk("R9 hit_cnt", int'(hit_cnt), 7);

        // R7 and R3: resolve and lookup of branch 0 in the same cycle
        do_reset();
        lk_idx = 2'd0; rs_idx = 2'd0; rs_taken = 1'b1; rs_valid = 1'b1;
        #1 chk("R7 old value seen", int'(lk_taken), 0);
        @(posedge clk);
        #1 rs_valid = 1'b0;
        chk("R8 same-cycle miss", int'(miss_cnt), 1);
        look(2'd0, 0, "R3 other pattern untouched");   // ghist=01
        look(2'd1, 0, "R3 other branch untouched");
        resolve(2'd1, 1'b0);
        resolve(2'd1, 1'b0);                           // ghist back to 00
        look(2'd0, 1, "R7 new value after edge");

        // R6: history disabled, last-outcome behaviour
        do_reset();
        hist_en = 1'b0;
        resolve(2'd2, 1'b1);
        look(2'd2, 1, "R6 last outcome taken");
        chk("R6 ghist still shifts", int'(ghist), 1);
        resolve(2'd1, 1'b0);
        look(2'd2, 1, "R6 independent of history");
        resolve(2'd2, 1'b0);
        look(2'd2, 0, "R6 last outcome not taken");
        hist_en = 1'b1;
        resolve(2'd3, 1'b1);                           // ghist 01
        look(2'd2, 0, "R6 pattern1 unwritten in flat mode");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule